// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard Controller

This block is the hazard-control engine for a floating-point pipeline with several functional units. Decoded instructions come in one at a time, in program order. The block gives each instruction to a free unit of the right class, or holds the front end with a stall. It then grants each unit the right to read its operands from the register file and, later, the right to write its result back. Between those two points the units run on their own and may overtake one another.

State is kept in three places. Each unit has an entry that records its stage, its destination and source register numbers, the units producing each source, and per-source ready flags. A register map holds, for each of the 32 floating-point registers, the unit that will write it. A pair of fixed-priority pickers grants at most one operand read and at most one result write per cycle. The check for a structural hazard or a repeated destination (WAW) happens at issue. The wait for producers (RAW) happens before operand read. The check that a pending reader still needs the old value (WAR) happens before write-back. There is no forwarding: a consumer reads its operands only after the producer has written the register file.

Top module: `sbd_issue_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every unit is free and the register map is empty: no grant is asserted, and a valid instruction of any class sees `issue_stall` low.
- R2: Instructions issue strictly in order, at most one per rising edge. While `issue_stall` is high, the presented instruction and every later one wait.
- R3: Class code 0 (integer) maps to unit 0, class 1 (multiply) to unit 1, or to unit 2 when unit 1 is busy, class 2 (add/sub) to unit 3, and class 3 (divide) to unit 4. A valid instruction whose unit(s) are all busy stalls. It issues on the edge after the one that registers that unit's write grant.
- R4: A valid instruction whose destination register already has a pending writer stalls (WAW). It issues on the edge after the one that registers that writer's write grant.
- R5: A unit whose sources have no pending producer gets its read grant on the edge after its issue. A unit waiting on a producer gets its read grant, at the earliest, on the edge after the producer's write grant. It reads no forwarded value.
- R6: An `fu_done` pulse sampled while its unit is executing marks the result complete, and the write grant follows on the next edge at the earliest. A pulse sampled while the unit is idle or still waiting for operands has no effect.
- R7: A completed unit may not write while another unit that has not yet read its operands names that unit's destination as a source with the ready flag set (WAR). The write grant follows on the edge after that reader's read grant.
- R8: At most one read grant is asserted per cycle. When several units are ready, the lowest unit index wins. Grant bit n belongs to unit n (0 integer, 1 mult-A, 2 mult-B, 3 add, 4 divide).
- R9: At most one write grant is asserted per cycle, with the same lowest-index priority and bit positions as R8.
- R10: A later independent instruction may read operands and write its result before an earlier instruction that is waiting on a RAW hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Operation class: 0 integer, 1 multiply, 2 add/sub, 3 divide |
| in_dst | input | REG_W | Destination register number |
| in_srcj | input | REG_W | First source register number |
| in_srck | input | REG_W | Second source register number |
| issue_stall | output | 1 | High while the presented instruction cannot issue this cycle |
| fu_done | input | 5 | Per-unit execution-complete pulse |
| rd_grant | output | 5 | Registered per-unit operand-read grant, one cycle wide |
| wr_grant | output | 5 | Registered per-unit result-write grant, one cycle wide |

## Verification
An instruction issues on the rising edge where `issue_stall` is low. A ready unit's read grant appears one edge later. Its write grant comes two edges after the edge where the bench's done model raised `fu_done`, so it lands at the read-grant edge plus the unit latency plus two. A RAW, WAR or WAW wait adds exactly one edge after the releasing grant. The driver computes every grant's due cycle from these rules and from the issue cycle it observed, then pushes it into a queue. A negedge monitor matches each observed grant against that queue by kind, unit and cycle, and any entry still left after a settling window counts as a missed grant. The issue cycles of stalled instructions are also compared against the cycle in which the blocking grant releases them.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int NUM_FU = 5;
  localparam int FU_W   = 3;
  localparam logic [FU_W-1:0] FU_NONE = {FU_W{1'b1}};

  localparam int FU_INT  = 0;
  localparam int FU_MUL1 = 1;
  localparam int FU_MUL2 = 2;
  localparam int FU_ADD  = 3;
  localparam int FU_DIV  = 4;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } fu_stage_e;
endpackage

// File: rtl/sbd_pick.sv
// Fixed-priority one-hot picker: lowest index wins.
module sbd_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbd_regstat.sv
// Register result map: which unit will write each register.
module sbd_regstat import sbd_pkg::*; #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] q_dst,
  input  logic [REG_W-1:0] q_srcj,
  input  logic [REG_W-1:0] q_srck,
  output logic [FU_W-1:0]  own_dst,
  output logic [FU_W-1:0]  own_srcj,
  output logic [FU_W-1:0]  own_srck,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [FU_W-1:0]  set_fu,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg
);
  localparam int NREG = 1 << REG_W;

  logic [FU_W-1:0] owner [NREG];

  assign own_dst  = owner[q_dst];
  assign own_srcj = owner[q_srcj];
  assign own_srck = owner[q_srck];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) owner[r] <= FU_NONE;
    end else begin
      if (clr_en) owner[clr_reg] <= FU_NONE;
      if (set_en) owner[set_reg] <= set_fu;
    end
  end

  // R4: a destination is never claimed while another unit still owns it
  a_r4_no_waw: assert property (@(posedge clk) disable iff (rst)
    set_en |-> owner[set_reg] == FU_NONE);
endmodule

// File: rtl/sbd_fu_table.sv
// Per-unit status entries with stage tracking, RAW wait and WAR scan.
module sbd_fu_table import sbd_pkg::*; #(
  parameter int REG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_en,
  input  logic [FU_W-1:0]   iss_fu,
  input  logic [REG_W-1:0]  iss_fi,
  input  logic [REG_W-1:0]  iss_fj,
  input  logic [REG_W-1:0]  iss_fk,
  input  logic [FU_W-1:0]   iss_qj,
  input  logic [FU_W-1:0]   iss_qk,
  input  logic [NUM_FU-1:0] done,
  input  logic [NUM_FU-1:0] rd_gnt,
  input  logic [NUM_FU-1:0] wr_gnt,
  output logic [NUM_FU-1:0] busy,
  output logic [NUM_FU-1:0] rd_req,
  output logic [NUM_FU-1:0] wr_req,
  output logic              wr_any,
  output logic [FU_W-1:0]   wr_fu,
  output logic [REG_W-1:0]  wr_fi
);
  logic [NUM_FU-1:0] busy_q, rj_q, rk_q, war_block;
  fu_stage_e         stage_q [NUM_FU];
  logic [REG_W-1:0]  fi_q [NUM_FU];
  logic [REG_W-1:0]  fj_q [NUM_FU];
  logic [REG_W-1:0]  fk_q [NUM_FU];
  logic [FU_W-1:0]   qj_q [NUM_FU];
  logic [FU_W-1:0]   qk_q [NUM_FU];
  logic [FU_W-1:0]   qj_eff, qk_eff;

  assign busy   = busy_q;
  assign wr_any = |wr_gnt;

  always_comb begin
    wr_fu = FU_NONE;
    wr_fi = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (wr_gnt[u]) begin
        wr_fu = FU_W'(u);
        wr_fi = fi_q[u];
      end
    end
  end

  // A producer writing in the issue cycle counts as already written.
  assign qj_eff = (wr_any && iss_qj == wr_fu) ? FU_NONE : iss_qj;
  assign qk_eff = (wr_any && iss_qk == wr_fu) ? FU_NONE : iss_qk;

  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_block[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u && busy_q[f] &&
            ((fj_q[f] == fi_q[u] && rj_q[f]) || (fk_q[f] == fi_q[u] && rk_q[f])))
          war_block[u] = 1'b1;
      end
      rd_req[u] = busy_q[u] && stage_q[u] == ST_WAIT && rj_q[u] && rk_q[u];
      wr_req[u] = busy_q[u] && stage_q[u] == ST_DONE && !war_block[u];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      rj_q   <= '0;
      rk_q   <= '0;
      for (int u = 0; u < NUM_FU; u++) begin
        stage_q[u] <= ST_IDLE;
        qj_q[u]    <= FU_NONE;
        qk_q[u]    <= FU_NONE;
        fi_q[u]    <= '0;
        fj_q[u]    <= '0;
        fk_q[u]    <= '0;
      end
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (wr_any && qj_q[u] == wr_fu) begin
          rj_q[u] <= 1'b1;
          qj_q[u] <= FU_NONE;
        end
        if (wr_any && qk_q[u] == wr_fu) begin
          rk_q[u] <= 1'b1;
          qk_q[u] <= FU_NONE;
        end
        if (wr_gnt[u]) begin
          busy_q[u]  <= 1'b0;
          stage_q[u] <= ST_IDLE;
        end else if (rd_gnt[u]) begin
          stage_q[u] <= ST_EXEC;
          rj_q[u]    <= 1'b0;
          rk_q[u]    <= 1'b0;
        end else if (done[u] && stage_q[u] == ST_EXEC) begin
          stage_q[u] <= ST_DONE;
        end
        if (iss_en && iss_fu == FU_W'(u)) begin
          busy_q[u]  <= 1'b1;
          stage_q[u] <= ST_WAIT;
          fi_q[u]    <= iss_fi;
          fj_q[u]    <= iss_fj;
          fk_q[u]    <= iss_fk;
          qj_q[u]    <= qj_eff;
          qk_q[u]    <= qk_eff;
          rj_q[u]    <= (qj_eff == FU_NONE);
          rk_q[u]    <= (qk_eff == FU_NONE);
        end
      end
    end
  end

  // R8 / R9: one grant of each kind per cycle
  a_r8_one_read: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_gnt));
  a_r9_one_write: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_gnt));

  for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
    // R5: a read grant moves the unit into execution and drops its flags
    a_r5_read_moves: assert property (@(posedge clk) disable iff (rst)
      rd_gnt[u] |=> (stage_q[u] == ST_EXEC && !rj_q[u] && !rk_q[u]));
    // R6: completion while waiting for operands is ignored
    a_r6_done_ignored: assert property (@(posedge clk) disable iff (rst)
      (done[u] && stage_q[u] == ST_WAIT && !rd_gnt[u]) |=> stage_q[u] == ST_WAIT);
    // R9: a write grant releases the unit
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
      wr_gnt[u] |=> !busy_q[u]);
    for (genvar f = 0; f < NUM_FU; f++) begin : g_pair
      if (f != u) begin : g_war
        // R7: no write while a pending reader still wants the old value
        a_r7_no_war: assert property (@(posedge clk) disable iff (rst)
          (wr_gnt[u] && busy_q[f]) |->
            !((fj_q[f] == fi_q[u] && rj_q[f]) || (fk_q[f] == fi_q[u] && rk_q[f])));
      end
    end
  end
endmodule

// File: rtl/sbd_issue_ctrl.sv
// Top: in-order issue, out-of-order operand read and write-back control.
module sbd_issue_ctrl import sbd_pkg::*; #(
  parameter int REG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_cls,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_srcj,
  input  logic [REG_W-1:0]  in_srck,
  output logic              issue_stall,
  input  logic [NUM_FU-1:0] fu_done,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wr_grant
);
  logic [NUM_FU-1:0] busy, rd_req, wr_req, rd_gnt, wr_gnt;
  logic [FU_W-1:0]   own_dst, own_srcj, own_srck, tgt_fu, wr_fu;
  logic [REG_W-1:0]  wr_fi;
  logic              wr_any, issue_fire;

  always_comb begin
    tgt_fu = FU_NONE;
    case (op_cls_e'(in_cls))
      CLS_INT: if (!busy[FU_INT]) tgt_fu = FU_W'(FU_INT);
      CLS_MUL: begin
        if (!busy[FU_MUL1])      tgt_fu = FU_W'(FU_MUL1);
        else if (!busy[FU_MUL2]) tgt_fu = FU_W'(FU_MUL2);
      end
      CLS_ADD: if (!busy[FU_ADD]) tgt_fu = FU_W'(FU_ADD);
      default: if (!busy[FU_DIV]) tgt_fu = FU_W'(FU_DIV);
    endcase
  end

  assign issue_stall = in_valid && (tgt_fu == FU_NONE || own_dst != FU_NONE);
  assign issue_fire  = in_valid && !issue_stall;

  sbd_regstat #(.REG_W(REG_W)) u_map (
    .clk(clk), .rst(rst),
    .q_dst(in_dst), .q_srcj(in_srcj), .q_srck(in_srck),
    .own_dst(own_dst), .own_srcj(own_srcj), .own_srck(own_srck),
    .set_en(issue_fire), .set_reg(in_dst), .set_fu(tgt_fu),
    .clr_en(wr_any), .clr_reg(wr_fi)
  );

  sbd_fu_table #(.REG_W(REG_W)) u_tab (
    .clk(clk), .rst(rst),
    .iss_en(issue_fire), .iss_fu(tgt_fu),
    .iss_fi(in_dst), .iss_fj(in_srcj), .iss_fk(in_srck),
    .iss_qj(own_srcj), .iss_qk(own_srck),
    .done(fu_done), .rd_gnt(rd_gnt), .wr_gnt(wr_gnt),
    .busy(busy), .rd_req(rd_req), .wr_req(wr_req),
    .wr_any(wr_any), .wr_fu(wr_fu), .wr_fi(wr_fi)
  );

  sbd_pick #(.N(NUM_FU)) u_rd_pick (.req(rd_req), .gnt(rd_gnt));
  sbd_pick #(.N(NUM_FU)) u_wr_pick (.req(wr_req), .gnt(wr_gnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_grant <= '0;
      wr_grant <= '0;
    end else begin
      rd_grant <= rd_gnt;
      wr_grant <= wr_gnt;
    end
  end

  // R5: a unit is never granted a read and a write in the same cycle
  a_r5_read_write_apart: assert property (@(posedge clk) disable iff (rst)
    (rd_grant & wr_grant) == '0);
endmodule

// File: tb/sbd_issue_ctrl_bench.sv
module sbd_issue_ctrl_bench;
  import sbd_pkg::*;

  logic       clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] in_cls = 2'd0;
  logic [4:0] in_dst = '0, in_srcj = '0, in_srck = '0;
  logic       issue_stall;
  logic [4:0] fu_done = '0, force_done = '0;
  logic [4:0] rd_grant, wr_grant;

  always #4 clk = ~clk;

  sbd_issue_ctrl u_sbd_issue_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_srcj(in_srcj), .in_srck(in_srck),
    .issue_stall(issue_stall), .fu_done(fu_done),
    .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;

  typedef struct {
    bit    is_wr;
    int    fu;
    int    at;
    string req;
  } ev_t;
  ev_t expq[$];

  int lat [NUM_FU] = '{1, 4, 4, 2, 6};
  int tmr [NUM_FU] = '{default: 0};

  // Fixed-latency unit model: done pulses LAT cycles after the read grant.
  always @(negedge clk) begin
    logic [4:0] d;
    d = force_done;
    for (int u = 0; u < NUM_FU; u++) begin
      if (tmr[u] > 0) begin
        tmr[u]--;
        if (tmr[u] == 0) d[u] = 1'b1;
      end
      if (rd_grant[u]) tmr[u] = lat[u];
    end
    fu_done = d;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input bit w, input int u, input int at, input string req);
    ev_t e;
    e.is_wr = w; e.fu = u; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  task automatic see(input bit w, input int u);
    int hit;
    hit = -1;
    n_chk++;
    foreach (expq[i])
      if (hit < 0 && expq[i].is_wr == w && expq[i].fu == u && expq[i].at == cyc) hit = i;
    if (hit < 0) begin
      n_err++;
      $display("FAIL %s: %s grant unit %0d at cycle %0d, actual=1 expected=0",
               w ? "R6" : "R5", w ? "write" : "read", u, cyc);
    end else begin
      expq.delete(hit);
    end
  endtask

  // Monitor: every observed grant must match a queued expectation.
  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < NUM_FU; u++) if (rd_grant[u]) see(1'b0, u);
      for (int u = 0; u < NUM_FU; u++) if (wr_grant[u]) see(1'b1, u);
    end
  end

  task automatic flush(input int n);
    repeat (n) @(negedge clk);
    #2;
    while (expq.size() > 0) begin
      ev_t e;
      e = expq.pop_front();
      n_chk++;
      n_err++;
      $display("FAIL %s: %s grant unit %0d due cycle %0d, actual=none expected=%0d",
               e.req, e.is_wr ? "write" : "read", e.fu, e.at, e.at);
    end
  endtask

  task automatic issue(input logic [1:0] c, input int d, input int j, input int k,
                       output int at);
    @(negedge clk);
    in_valid = 1'b1; in_cls = c;
    in_dst = 5'(d); in_srcj = 5'(j); in_srck = 5'(k);
    #1;
    while (issue_stall) begin
      @(negedge clk);
      #1;
    end
    at = cyc + 1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  int t0, t1, t2, t3;

  initial begin
    #(8 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk(rd_grant == 5'd0, "R1 read grants after reset", rd_grant, 0);
    chk(wr_grant == 5'd0, "R1 write grants after reset", wr_grant, 0);
    for (int c = 0; c < 4; c++) begin
      in_valid = 1'b1; in_cls = 2'(c); in_dst = 5'(c);
      #1;
      chk(issue_stall == 1'b0, "R1 no stall for free unit", issue_stall, 0);
    end
    in_valid = 1'b0;

    // R6: done pulses while every unit is idle are ignored
    @(negedge clk);
    force_done = 5'b11111;
    @(negedge clk);
    #1 force_done = '0;
    repeat (3) begin
      @(negedge clk);
      chk(wr_grant == 5'd0, "R6 idle done ignored", wr_grant, 0);
    end

    // R5: single independent add into the top register
    issue(2'd2, 31, 4, 6, t0);
    expect_ev(0, FU_ADD, t0 + 1, "R5");
    expect_ev(1, FU_ADD, t0 + 5, "R6");
    flush(12);

    // R5/R10: RAW wait, independent integer op overtakes
    issue(2'd1, 0, 2, 4, t0);
    expect_ev(0, FU_MUL1, t0 + 1, "R5");
    expect_ev(0, FU_INT,  t0 + 3, "R10");
    expect_ev(1, FU_INT,  t0 + 6, "R10");
    expect_ev(1, FU_MUL1, t0 + 7, "R6");
    expect_ev(0, FU_ADD,  t0 + 8, "R5 RAW");
    expect_ev(1, FU_ADD,  t0 + 12, "R6");
    issue(2'd2, 8, 0, 6, t1);
    chk(t1 == t0 + 1, "R2 add issues next edge", t1, t0 + 1);
    issue(2'd0, 10, 12, 14, t2);
    chk(t2 == t0 + 2, "R10 int issues behind waiting add", t2, t0 + 2);
    force_done = 5'b01000;   // R6: done to the add while it waits for operands
    @(negedge clk);
    #1 force_done = '0;
    flush(20);

    // R3/R2: both multipliers busy, later add held behind the stalled multiply
    issue(2'd1, 0, 2, 4, t0);
    issue(2'd1, 6, 8, 10, t1);
    chk(t1 == t0 + 1, "R3 second multiply issues", t1, t0 + 1);
    expect_ev(0, FU_MUL1, t0 + 1, "R3");
    expect_ev(0, FU_MUL2, t0 + 2, "R3 second unit");
    expect_ev(1, FU_MUL1, t0 + 7, "R6");
    expect_ev(1, FU_MUL2, t0 + 8, "R6");
    expect_ev(0, FU_MUL1, t0 + 9, "R3 reissue");
    expect_ev(0, FU_ADD,  t0 + 10, "R2");
    expect_ev(1, FU_ADD,  t0 + 14, "R6");
    expect_ev(1, FU_MUL1, t0 + 15, "R6");
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'd1; in_dst = 5'd12; in_srcj = 5'd14; in_srck = 5'd16;
    #1;
    chk(issue_stall == 1'b1, "R3 stall with both multipliers busy", issue_stall, 1);
    issue(2'd1, 12, 14, 16, t2);
    chk(t2 == t0 + 8, "R3 issue after unit release", t2, t0 + 8);
    issue(2'd2, 18, 20, 22, t3);
    chk(t3 == t0 + 9, "R2 add waits behind stalled multiply", t3, t0 + 9);
    flush(20);

    // R4: WAW stall on a pending destination
    issue(2'd3, 6, 2, 4, t0);
    expect_ev(0, FU_DIV, t0 + 1, "R5");
    expect_ev(1, FU_DIV, t0 + 9, "R6");
    expect_ev(0, FU_ADD, t0 + 11, "R4");
    expect_ev(1, FU_ADD, t0 + 15, "R4");
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'd2; in_dst = 5'd6; in_srcj = 5'd8; in_srck = 5'd10;
    #1;
    chk(issue_stall == 1'b1, "R4 stall on pending destination", issue_stall, 1);
    issue(2'd2, 6, 8, 10, t1);
    chk(t1 == t0 + 10, "R4 issue after writer clears", t1, t0 + 10);
    flush(20);

    // R7: integer result held until the waiting add reads its old source
    issue(2'd3, 0, 2, 4, t0);
    expect_ev(0, FU_DIV, t0 + 1, "R5");
    expect_ev(0, FU_INT, t0 + 3, "R5");
    expect_ev(1, FU_DIV, t0 + 9, "R6");
    expect_ev(0, FU_ADD, t0 + 10, "R5 RAW");
    expect_ev(1, FU_INT, t0 + 11, "R7 WAR");
    expect_ev(1, FU_ADD, t0 + 14, "R6");
    issue(2'd2, 10, 0, 8, t1);
    issue(2'd0, 8, 12, 14, t2);
    chk(t2 == t0 + 2, "R7 writer issues despite pending reader", t2, t0 + 2);
    flush(20);

    // R8: two readers released by the same producer
    issue(2'd3, 0, 2, 4, t0);
    expect_ev(0, FU_DIV, t0 + 1, "R5");
    expect_ev(1, FU_DIV, t0 + 9, "R6");
    expect_ev(0, FU_INT, t0 + 10, "R8 priority");
    expect_ev(0, FU_ADD, t0 + 11, "R8 priority");
    expect_ev(1, FU_INT, t0 + 13, "R6");
    expect_ev(1, FU_ADD, t0 + 15, "R6");
    issue(2'd2, 6, 0, 2, t1);
    issue(2'd0, 8, 0, 4, t2);
    flush(20);

    // R9: two writers complete together
    issue(2'd1, 0, 2, 4, t0);
    expect_ev(0, FU_MUL1, t0 + 1, "R5");
    expect_ev(0, FU_INT,  t0 + 4, "R5");
    expect_ev(1, FU_INT,  t0 + 7, "R9 priority");
    expect_ev(1, FU_MUL1, t0 + 8, "R9 priority");
    repeat (2) @(negedge clk);
    issue(2'd0, 12, 14, 16, t1);
    chk(t1 == t0 + 3, "R9 int issue timing", t1, t0 + 3);
    flush(20);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule